// File: doc/BRIEF.md
# Dual-Channel DAC Serial Control Slave

This block is the digital front end of a two-channel 8-bit digital-to-analog converter. A host reaches it over a three-wire synchronous serial link made of a serial clock, a data input and an active-low select. The block works with both SPI-style and Microwire-style masters. While the select is low, each rising edge of the serial clock shifts in one bit, most significant bit first. When the select returns high, the last twelve bits received form a control word. That word is split into a 2-bit channel selector, a 2-bit power-down command and an 8-bit conversion code. The results are held in registers that drive the analog converters, which are outside this block.

The serial pins are asynchronous to the block clock. They pass through a small synchronizer, and every edge of the serial clock and of the select is detected in the block clock domain. The serial clock must therefore be several block clock periods long. The data output is full duplex. During each frame it plays back the previous accepted control word, one bit per falling serial-clock edge, address bits first. It is always driven and never floats. A frame of sixteen bits is accepted by dropping its first four bits. A frame may also arrive as a 4-bit packet and then an 8-bit packet within a single select-low period.

Top module: `dac_ser_ctrl`

## Requirements
- R1: After reset both codes are 0, all three power-down flags are 0, both output enables are 0 and `dout` is 0.
- R2: While `cs_n` is low, `din` is sampled on each rising `sclk` edge. When `cs_n` rises after at least 12 samples, the 12 most recent bits form the word: the first of them is word bit 11, and a longer frame (such as 16 bits) loses its earliest bits.
- R3: Word bits [11:10] select the channels: 01 loads bits [7:0] into `code_a`, 10 loads them into `code_b`, and 11 loads the same value into both codes.
- R4: A word whose selector is 00 leaves both codes, all power-down flags and both enables unchanged.
- R5: Any word with a non-zero selector rewrites the power flags from bits [9:8]: 00 clears all three, 01 sets only `pd_a`, 10 sets only `pd_b`, 11 sets only `pd_all`. At most one flag is ever set.
- R6: `oe_a` is 1 exactly when channel A has been loaded since reset and neither `pd_a` nor `pd_all` is set; `oe_b` follows the same rule with `pd_b`.
- R7: A frame with fewer than 12 samples changes no code, flag or enable, and does not change the word played back on `dout` in the next frame.
- R8: In a frame, the k-th falling `sclk` edge (k = 1..12) drives `dout` to bit 12-k of the last accepted word; later falling edges in that frame drive 0. `dout` changes only after a falling `sclk` edge seen with `cs_n` low.
- R9: While `cs_n` is high, `sclk` and `din` activity changes neither the outputs nor `dout`.
- R10: A word sent as 4 bits, then a pause with `sclk` low, then 8 bits, all within one `cs_n`-low period, gives the same result as a continuous 12-bit frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data in, MSB first |
| dout | output | 1 | Serial playback of the previous accepted word |
| code_a | output | 8 | Conversion code for channel A |
| code_b | output | 8 | Conversion code for channel B |
| pd_a | output | 1 | Channel A powered down |
| pd_b | output | 1 | Channel B powered down |
| pd_all | output | 1 | Whole device powered down |
| oe_a | output | 1 | Channel A output driven |
| oe_b | output | 1 | Channel B output driven |

## Verification
The main sweep sends 256 twelve-bit words. Their selector and power fields run through all sixteen combinations many times, and their codes are spread over the full 8-bit range. This separates channel steering, the power-flag encodings, the no-op selector and the enable rule. Every frame also compares its playback bits against the word accepted before it. Sixteen-bit frames whose first four bits hold varying values show that only the last twelve bits count. A split 4+8 frame shows that a pause inside a frame is harmless. Short frames of 1, 5 and 11 bits, and serial-clock toggling with the select high, show that the state and the playback word survive both.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  localparam int SEL_W = 2;
  localparam int PWR_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10,
    SEL_BOTH = 2'b11
  } sel_e;

  typedef enum logic [PWR_W-1:0] {
    PWR_ON      = 2'b00,
    PWR_OFF_A   = 2'b01,
    PWR_OFF_B   = 2'b10,
    PWR_OFF_ALL = 2'b11
  } pwr_e;
endpackage

// File: rtl/dac_ser_sync.sv
// Multi-stage synchronizer with edge detection, one chain per input bit.
module dac_ser_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic [STAGES:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {(STAGES+1){RST_VAL[g]}};
        else        chain <= {chain[STAGES-1:0], d_in[g]};
      end
      assign q[g]    = chain[STAGES-1];
      assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
      assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
    end
  endgenerate
endmodule

// File: rtl/dac_ser_rx.sv
// Input shift register and bit counter; flags a complete frame at select release.
module dac_ser_rx #(
  parameter int WORD_W = 12,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low,
  input  logic              cs_start,
  input  logic              cs_end,
  input  logic              sclk_rise,
  input  logic              din,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_NEED = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take;

  assign take = sclk_rise & cs_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (take) shift_q <= {shift_q[WORD_W-2:0], din};
      if (cs_start)                     cnt_q <= '0;
      else if (take && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o     = shift_q;
  assign frame_ok_o = cs_end & (cnt_q >= CNT_NEED);
endmodule

// File: rtl/dac_ser_regs.sv
// Word decode into code registers, power flags and output enables.
module dac_ser_regs
  import dac_ser_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEL_W-1:0]  sel,
  input  logic [PWR_W-1:0]  pwr,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              pd_a_o,
  output logic              pd_b_o,
  output logic              pd_all_o,
  output logic              oe_a_o,
  output logic              oe_b_o
);
  logic wr_a_q, wr_b_q;
  logic hit_a, hit_b, act;

  assign act   = load && (sel != SEL_NONE);
  assign hit_a = act && (sel == SEL_A || sel == SEL_BOTH);
  assign hit_b = act && (sel == SEL_B || sel == SEL_BOTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a_o <= '0;
      code_b_o <= '0;
      pd_a_o   <= 1'b0;
      pd_b_o   <= 1'b0;
      pd_all_o <= 1'b0;
      wr_a_q   <= 1'b0;
      wr_b_q   <= 1'b0;
    end else begin
      if (act) begin
        pd_a_o   <= (pwr == PWR_OFF_A);
        pd_b_o   <= (pwr == PWR_OFF_B);
        pd_all_o <= (pwr == PWR_OFF_ALL);
      end
      if (hit_a) begin
        code_a_o <= code;
        wr_a_q   <= 1'b1;
      end
      if (hit_b) begin
        code_b_o <= code;
        wr_b_q   <= 1'b1;
      end
    end
  end

  assign oe_a_o = wr_a_q & ~pd_a_o & ~pd_all_o;
  assign oe_b_o = wr_b_q & ~pd_b_o & ~pd_all_o;
endmodule

// File: rtl/dac_ser_echo.sv
// Holds the last accepted word and plays it back on falling serial-clock edges.
module dac_ser_echo #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              cs_start,
  input  logic              cs_low,
  input  logic              sclk_fall,
  output logic              dout_o
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tx_q   <= '0;
      dout_o <= 1'b0;
    end else begin
      if (load) hold_q <= word;
      if (cs_start) begin
        tx_q <= hold_q;
      end else if (sclk_fall && cs_low) begin
        dout_o <= tx_q[WORD_W-1];
        tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/dac_ser_ctrl.sv
module dac_ser_ctrl
  import dac_ser_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              pd_a,
  output logic              pd_b,
  output logic              pd_all,
  output logic              oe_a,
  output logic              oe_b
);
  localparam int WORD_W = SEL_W + PWR_W + CODE_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [2:0] pin_q, pin_rise, pin_fall;
  logic       cs_low, cs_start, cs_end, sclk_rise, sclk_fall;
  logic [WORD_W-1:0] rx_word;
  logic       frame_ok;

  dac_ser_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({cs_n, sclk, din}),
    .q(pin_q), .rise(pin_rise), .fall(pin_fall)
  );

  assign cs_low    = ~pin_q[2];
  assign cs_start  = pin_fall[2];
  assign cs_end    = pin_rise[2];
  assign sclk_rise = pin_rise[1];
  assign sclk_fall = pin_fall[1];

  dac_ser_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_low(cs_low), .cs_start(cs_start), .cs_end(cs_end),
    .sclk_rise(sclk_rise), .din(pin_q[0]),
    .word_o(rx_word), .frame_ok_o(frame_ok)
  );

  dac_ser_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(frame_ok),
    .sel(rx_word[WORD_W-1 -: SEL_W]),
    .pwr(rx_word[CODE_W +: PWR_W]),
    .code(rx_word[CODE_W-1:0]),
    .code_a_o(code_a), .code_b_o(code_b),
    .pd_a_o(pd_a), .pd_b_o(pd_b), .pd_all_o(pd_all),
    .oe_a_o(oe_a), .oe_b_o(oe_b)
  );

  dac_ser_echo #(.WORD_W(WORD_W)) u_echo (
    .clk(clk), .rst_n(rst_n), .load(frame_ok), .word(rx_word),
    .cs_start(cs_start), .cs_low(cs_low), .sclk_fall(sclk_fall),
    .dout_o(dout)
  );
endmodule

// File: rtl/dac_ser_chk.sv
module dac_ser_chk #(
  parameter int CODE_W = 8,
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_done,
  input logic [WORD_W-1:0] word,
  input logic              sclk_fall,
  input logic              dout,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              pd_a,
  input logic              pd_b,
  input logic              pd_all,
  input logic              oe_a,
  input logic              oe_b
);
  a_r3_codes_move_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done |=> ($stable(code_a) && $stable(code_b)));

  a_r4_nop_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && word[WORD_W-1 -: 2] == 2'b00) |=>
      $stable({code_a, code_b, pd_a, pd_b, pd_all, oe_a, oe_b}));

  a_r5_pd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_a, pd_b, pd_all}));

  a_r6_oe_a_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_a) |-> $past(frm_done));

  a_r6_oe_b_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_b) |-> $past(frm_done));

  a_r8_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(dout));
endmodule

bind dac_ser_ctrl dac_ser_chk #(.CODE_W(CODE_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_done(frame_ok), .word(rx_word),
  .sclk_fall(sclk_fall), .dout(dout), .code_a(code_a), .code_b(code_b),
  .pd_a(pd_a), .pd_b(pd_b), .pd_all(pd_all), .oe_a(oe_a), .oe_b(oe_b)
);

// File: tb/test_dac_ser_ctrl.sv
module test_dac_ser_ctrl;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout, pd_a, pd_b, pd_all, oe_a, oe_b;
  logic [7:0] code_a, code_b;

  always #2.5 clk = ~clk;

  dac_ser_ctrl i_dac_ser_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .code_a(code_a), .code_b(code_b), .pd_a(pd_a), .pd_b(pd_b),
    .pd_all(pd_all), .oe_a(oe_a), .oe_b(oe_b)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // model state
  logic [7:0]  m_ca = 0, m_cb = 0;
  logic        m_pa = 0, m_pb = 0, m_pall = 0, m_wa = 0, m_wb = 0;
  logic [11:0] m_echo = 0;
  logic        m_dout = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(input string tc);
    chk(tc, {16'h0, code_a, code_b}, {16'h0, m_ca, m_cb});
    chk("R5", {29'h0, pd_a, pd_b, pd_all}, {29'h0, m_pa, m_pb, m_pall});
    chk("R6", {30'h0, oe_a, oe_b},
        {30'h0, m_wa & ~m_pa & ~m_pall, m_wb & ~m_pb & ~m_pall});
  endtask

  // Send n bits (bits[n-1] first); optional pause after the first 4 bits.
  task automatic send(input logic [15:0] bits, input int n, input bit split, input string td);
    logic [15:0] got, exp;
    logic [11:0] w;
    got = '0; exp = '0;
    cs_n = 1'b0;
    wt(2*H);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i];
      wt(H); sclk = 1'b1;
      wt(H); sclk = 1'b0;
      wt(H);
      got[i] = dout;
      exp[i] = (n - i <= 12) ? m_echo[12 - (n - i)] : 1'b0;
      if (split && (n - i) == 4) wt(8*H);
    end
    if (n > 0) m_dout = got[0];
    chk(td, {16'h0, got}, {16'h0, exp});
    cs_n = 1'b1;
    wt(3*H);
    chk(td, {31'h0, dout}, {31'h0, m_dout});
    if (n >= 12) begin
      w = bits[11:0];
      if (w[11:10] != 2'b00) begin
        m_pa = (w[9:8] == 2'b01);
        m_pb = (w[9:8] == 2'b10);
        m_pall = (w[9:8] == 2'b11);
        if (w[10]) begin m_ca = w[7:0]; m_wa = 1'b1; end
        if (w[11]) begin m_cb = w[7:0]; m_wb = 1'b1; end
      end
      m_echo = w;
    end
  endtask

  initial begin
    wt(4);
    rst_n = 1'b1;
    wt(4);
    // R1: reset state
    chk("R1", {13'h0, code_a, code_b, pd_a, pd_b, pd_all, oe_a, oe_b}, 32'h0);
    chk("R1", {31'h0, dout}, 32'h0);

    // R2 R3 R4 R5 R6 R8: sweep of selector, power and code
    for (int i = 0; i < 256; i++) begin
      logic [11:0] w;
      w = {2'(i % 4), 2'((i / 4) % 4), 8'((i * 37 + 11) % 256)};
      send({4'h0, w}, 12, 1'b0, "R8");
      check_state((w[11:10] == 2'b00) ? "R4" : "R3");
    end

    // R2: 16-bit frames, first four bits discarded
    for (int j = 0; j < 6; j++) begin
      logic [11:0] w;
      w = {2'((j % 3) + 1), 2'(j % 4), 8'(8'hC3 ^ 8'(j * 29))};
      send({4'(j * 5 + 3), w}, 16, 1'b0, "R2");
      check_state("R2");
    end

    // R10: 4-bit then 8-bit packet in one select period
    send({4'h0, 2'b11, 2'b00, 8'h5A}, 12, 1'b1, "R10");
    check_state("R10");
    send({4'h0, 2'b01, 2'b10, 8'hA7}, 12, 1'b1, "R10");
    check_state("R10");

    // R7: short frames are discarded
    send(16'h0FFF, 1, 1'b0, "R7");
    check_state("R7");
    send(16'h001F, 5, 1'b0, "R7");
    check_state("R7");
    send(16'h07FF, 11, 1'b0, "R7");
    check_state("R7");
    send({4'h0, 2'b10, 2'b00, 8'h3C}, 12, 1'b0, "R7");
    check_state("R3");

    // R9: serial clock activity with select high is ignored
    for (int k = 0; k < 20; k++) begin
      din = k[0];
      wt(H); sclk = 1'b1;
      wt(H); sclk = 1'b0;
    end
    wt(3*H);
    check_state("R9");
    chk("R9", {31'h0, dout}, {31'h0, m_dout});
    send({4'h0, 2'b11, 2'b11, 8'h81}, 12, 1'b0, "R9");
    check_state("R9");

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule